// File: doc/BRIEF.md
# Row-Burst Memory Access Scheduler

This block sits in front of an SDRAM command stage. It takes read and write requests, each tagged with bank, row, column, direction and a tag, and reorders them to make better use of the data bus. It does not issue them in arrival order. Each bank has its own request queue. For each bank the scheduler tracks the row that was last used. Requests that hit that row are issued as a run, so row switches become rarer.

Reads are favoured over writes. A write that hits the open row rides at the tail of the current run and does not start a new run of its own. When too many writes are waiting, writes are drained first. Banks take turns in round-robin order, so runs from different banks interleave. Requests within one bank that touch the same address are never reordered when a write is involved. One request leaves per cycle through a valid/ready handshake.

Top module: `row_burst_sched`

## Requirements
- R1: After reset, `out_valid_o` is 0 and `in_ready_o` is 1 for every bank.
- R2: Within a bank, once a row is open (the row of that bank's last issued request), every eligible pending read to that row issues, oldest first, before any request to another row.
- R3: While fewer than `WR_THRESH` writes are queued in total, a bank with no open-row hit issues its oldest eligible read ahead of any older write.
- R4: When the total number of queued writes is at or above `WR_THRESH` (default 6), the next request issued is a write: the oldest eligible write of the chosen bank, with the choice limited to banks that hold an eligible write.
- R5: A write to a bank's open row issues after that bank's open-row reads are used up and before any request to a different row.
- R6: Each bank queue holds `DEPTH` (default 8) entries. `in_ready_o` is 0 while the bank on `in_bank_i` is full, and a request offered to a full bank is not accepted. Other banks are unaffected.
- R7: Banks with pending work are served round-robin, starting at the bank after the one served last. After reset, bank 0 is searched first.
- R8: A request never passes an older request in the same bank with identical row and column when either of the two is a write.
- R9: A request leaves only when `out_valid_o` and `out_ready_i` are both 1, at most one per cycle, and it is removed from its queue in that cycle. `out_valid_o` stays 1 while `out_ready_i` is 0 and is 0 when all queues are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request offered |
| in_ready_o | output | 1 | Queue of `in_bank_i` has space |
| in_bank_i | input | $clog2(NUM_BANKS) | Target bank |
| in_row_i | input | ROW_W | Target row |
| in_col_i | input | COL_W | Target column |
| in_write_i | input | 1 | 1 = write, 0 = read |
| in_tag_i | input | TAG_W | Request tag |
| out_valid_o | output | 1 | A request is selected |
| out_ready_i | input | 1 | Command stage accepts |
| out_bank_o | output | $clog2(NUM_BANKS) | Bank of selected request |
| out_row_o | output | ROW_W | Row of selected request |
| out_col_o | output | COL_W | Column of selected request |
| out_write_o | output | 1 | Direction of selected request |
| out_tag_o | output | TAG_W | Tag of selected request |

## Verification
A request accepted at a clock edge is stored in its queue at that edge. From the next cycle it can appear on the output, which is combinational from queue and open-row state. Each issue removes the entry and updates the open row and the round-robin pointer at the same edge, so the following selection shows up one cycle later. The bench loads every scenario with `out_ready_i` low, then raises it. The monitor samples on the falling edge and compares each handshake, in order, against a scoreboard queue. That queue is filled with the issue order worked out from the requirements.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  parameter int ROW_W = 13;
  parameter int COL_W = 10;
  parameter int TAG_W = 8;

  typedef struct packed {
    logic             wr;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic [TAG_W-1:0] tag;
  } rbs_req_t;
endpackage

// File: rtl/rbs_bank_queue.sv
module rbs_bank_queue
  import rbs_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  push_i,
  input  rbs_req_t              push_req_i,
  input  logic                  pop_i,
  input  logic [IDX_W-1:0]      pop_idx_i,
  output rbs_req_t [DEPTH-1:0]  ent_o,
  output logic [DEPTH-1:0]      vld_o,
  output logic [CNT_W-1:0]      cnt_o,
  output logic                  full_o
);
  rbs_req_t [DEPTH-1:0] q_q, q_n;
  logic [CNT_W-1:0]     cnt_q, cnt_mid, cnt_n;

  always_comb begin
    q_n = q_q;
    if (pop_i)
      for (int i = 0; i < DEPTH - 1; i++)
        if (i >= int'(pop_idx_i)) q_n[i] = q_q[i+1];
    cnt_mid = cnt_q - CNT_W'(pop_i);
    if (push_i) q_n[cnt_mid[IDX_W-1:0]] = push_req_i;
    cnt_n = cnt_mid + CNT_W'(push_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= '0;
      cnt_q <= '0;
    end else begin
      q_q   <= q_n;
      cnt_q <= cnt_n;
    end
  end

  always_comb
    for (int i = 0; i < DEPTH; i++) vld_o[i] = CNT_W'(i) < cnt_q;

  assign ent_o  = q_q;
  assign cnt_o  = cnt_q;
  assign full_o = cnt_q == CNT_W'(DEPTH);
endmodule

// File: rtl/rbs_pick.sv
module rbs_pick
  import rbs_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  rbs_req_t [DEPTH-1:0] ent_i,
  input  logic [DEPTH-1:0]     vld_i,
  input  logic                 open_vld_i,
  input  logic [ROW_W-1:0]     open_row_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     norm_idx_o,
  output logic                 wr_any_o,
  output logic [IDX_W-1:0]     wr_idx_o
);
  logic [DEPTH-1:0] elig, hit;
  logic             f_rh, f_wh, f_rd, f_wr;
  logic [IDX_W-1:0] i_rh, i_wh, i_rd, i_wr;

  always_comb begin
    // an entry may not pass an older same-address entry if a write is involved
    for (int i = 0; i < DEPTH; i++) begin
      elig[i] = vld_i[i];
      hit[i]  = open_vld_i && (ent_i[i].row == open_row_i);
      for (int j = 0; j < DEPTH; j++)
        if (j < i && vld_i[j] && ent_i[j].row == ent_i[i].row &&
            ent_i[j].col == ent_i[i].col && (ent_i[j].wr || ent_i[i].wr))
          elig[i] = 1'b0;
    end
    {f_rh, f_wh, f_rd, f_wr} = '0;
    {i_rh, i_wh, i_rd, i_wr} = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (elig[i] && !ent_i[i].wr && hit[i]) begin f_rh = 1'b1; i_rh = IDX_W'(i); end
      if (elig[i] &&  ent_i[i].wr && hit[i]) begin f_wh = 1'b1; i_wh = IDX_W'(i); end
      if (elig[i] && !ent_i[i].wr)           begin f_rd = 1'b1; i_rd = IDX_W'(i); end
      if (elig[i] &&  ent_i[i].wr)           begin f_wr = 1'b1; i_wr = IDX_W'(i); end
    end
    norm_idx_o = f_rh ? i_rh : f_wh ? i_wh : f_rd ? i_rd : i_wr;
  end

  assign any_o    = |elig;
  assign wr_any_o = f_wr;
  assign wr_idx_o = i_wr;
endmodule

// File: rtl/rbs_rr_arb.sv
module rbs_rr_arb #(
  parameter int N   = 4,
  parameter int N_W = $clog2(N)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   req_i,
  input  logic           adv_i,
  output logic [N-1:0]   gnt_o,
  output logic [N_W-1:0] gnt_idx_o
);
  logic [N_W-1:0] last_q;

  always_comb begin
    gnt_o     = '0;
    gnt_idx_o = '0;
    for (int k = N; k >= 1; k--) begin
      int b;
      b = (int'(last_q) + k) % N;
      if (req_i[b]) begin
        gnt_o     = '0;
        gnt_o[b]  = 1'b1;
        gnt_idx_o = N_W'(b);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_q <= N_W'(N - 1);
    else if (adv_i) last_q <= gnt_idx_o;
  end
endmodule

// File: rtl/row_burst_sched.sv
module row_burst_sched
  import rbs_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int DEPTH     = 8,
  parameter int WR_THRESH = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [BANK_W-1:0] in_bank_i,
  input  logic [ROW_W-1:0]  in_row_i,
  input  logic [COL_W-1:0]  in_col_i,
  input  logic              in_write_i,
  input  logic [TAG_W-1:0]  in_tag_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [BANK_W-1:0] out_bank_o,
  output logic [ROW_W-1:0]  out_row_o,
  output logic [COL_W-1:0]  out_col_o,
  output logic              out_write_o,
  output logic [TAG_W-1:0]  out_tag_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int WC_W  = $clog2(NUM_BANKS * DEPTH + 1);

  rbs_req_t [DEPTH-1:0]      ent   [NUM_BANKS];
  logic [DEPTH-1:0]          vld   [NUM_BANKS];
  logic [IDX_W-1:0]          nidx  [NUM_BANKS];
  logic [IDX_W-1:0]          widx  [NUM_BANKS];
  logic [IDX_W-1:0]          cidx  [NUM_BANKS];
  logic [ROW_W-1:0]          open_row_q [NUM_BANKS];
  logic [NUM_BANKS-1:0]      open_vld_q, full, any, wr_any, cand, push, pop, gnt;
  logic [NUM_BANKS*CNT_W-1:0] cnt_flat;
  logic [BANK_W-1:0]         gnt_idx;
  logic [WC_W-1:0]           wr_cnt_q;
  logic                      drain, fire, in_fire;
  rbs_req_t                  in_req, sel;

  assign in_req     = '{wr: in_write_i, row: in_row_i, col: in_col_i, tag: in_tag_i};
  assign in_ready_o = !full[in_bank_i];
  assign in_fire    = in_valid_i && in_ready_o;
  assign drain      = wr_cnt_q >= WC_W'(WR_THRESH);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign push[b] = in_fire && (in_bank_i == BANK_W'(b));
    assign pop[b]  = fire && gnt[b];

    rbs_bank_queue #(.DEPTH(DEPTH)) u_q (
      .clk_i, .rst_ni,
      .push_i(push[b]), .push_req_i(in_req),
      .pop_i(pop[b]), .pop_idx_i(cidx[b]),
      .ent_o(ent[b]), .vld_o(vld[b]),
      .cnt_o(cnt_flat[b*CNT_W +: CNT_W]), .full_o(full[b])
    );

    rbs_pick #(.DEPTH(DEPTH)) u_pick (
      .ent_i(ent[b]), .vld_i(vld[b]),
      .open_vld_i(open_vld_q[b]), .open_row_i(open_row_q[b]),
      .any_o(any[b]), .norm_idx_o(nidx[b]),
      .wr_any_o(wr_any[b]), .wr_idx_o(widx[b])
    );

    // write drain limits the field to banks holding an eligible write
    assign cand[b] = (drain && |wr_any) ? wr_any[b] : any[b];
    assign cidx[b] = (drain && |wr_any) ? widx[b]   : nidx[b];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_vld_q[b] <= 1'b0;
        open_row_q[b] <= '0;
      end else if (pop[b]) begin
        open_vld_q[b] <= 1'b1;
        open_row_q[b] <= ent[b][cidx[b]].row;
      end
    end
  end

  rbs_rr_arb #(.N(NUM_BANKS)) u_arb (
    .clk_i, .rst_ni, .req_i(cand), .adv_i(fire),
    .gnt_o(gnt), .gnt_idx_o(gnt_idx)
  );

  always_comb begin
    sel = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (gnt[b]) sel = ent[b][cidx[b]];
  end

  assign out_valid_o = |cand;
  assign fire        = out_valid_o && out_ready_i;
  assign out_bank_o  = gnt_idx;
  assign out_row_o   = sel.row;
  assign out_col_o   = sel.col;
  assign out_write_o = sel.wr;
  assign out_tag_o   = sel.tag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_cnt_q <= '0;
    else wr_cnt_q <= wr_cnt_q + WC_W'(in_fire && in_write_i) - WC_W'(fire && sel.wr);
  end
endmodule

// File: rtl/rbs_checker.sv
module rbs_checker #(
  parameter int NUM_BANKS = 4,
  parameter int DEPTH     = 8,
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       out_valid_i,
  input logic                       out_ready_i,
  input logic                       in_fire_i,
  input logic [NUM_BANKS-1:0]       gnt_i,
  input logic [NUM_BANKS*CNT_W-1:0] cnt_flat_i
);
  logic [15:0] occ;

  always_comb begin
    occ = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      occ = occ + 16'(cnt_flat_i[b*CNT_W +: CNT_W]);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    p_depth_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(cnt_flat_i[b*CNT_W +: CNT_W]) <= DEPTH);
  end

  p_hold_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i && !out_ready_i |=> out_valid_i);

  p_idle_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ == 16'd0 |-> !out_valid_i);

  p_pop_one_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i && out_ready_i && !in_fire_i |=> occ == $past(occ) - 16'd1);

  p_one_grant_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_i));

  p_grant_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i |-> gnt_i != '0);
endmodule

bind row_burst_sched rbs_checker #(
  .NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .out_valid_i(out_valid_o), .out_ready_i(out_ready_i),
  .in_fire_i(in_fire), .gnt_i(gnt), .cnt_flat_i(cnt_flat)
);

// File: tb/sim_row_burst_sched.sv
module sim_row_burst_sched;
  import rbs_pkg::*;

  logic             clk = 1'b0, rst_n = 1'b0;
  logic             in_valid = 1'b0, in_write = 1'b0, out_ready = 1'b0;
  logic [1:0]       in_bank = '0;
  logic [ROW_W-1:0] in_row = '0;
  logic [COL_W-1:0] in_col = '0;
  logic [TAG_W-1:0] in_tag = '0;
  logic             in_ready_o, out_valid_o, out_write_o;
  logic [1:0]       out_bank_o;
  logic [ROW_W-1:0] out_row_o;
  logic [COL_W-1:0] out_col_o;
  logic [TAG_W-1:0] out_tag_o;

  int n_run = 0, n_fail = 0;
  typedef struct { int tag; int bank; string rq; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  row_burst_sched u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready_o), .in_bank_i(in_bank),
    .in_row_i(in_row), .in_col_i(in_col), .in_write_i(in_write), .in_tag_i(in_tag),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready), .out_bank_o(out_bank_o),
    .out_row_o(out_row_o), .out_col_o(out_col_o), .out_write_o(out_write_o),
    .out_tag_o(out_tag_o)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic push(input int b, input int row, input int col, input bit wr, input int tag);
    @(posedge clk); #1;
    in_valid = 1'b1; in_bank = 2'(b); in_row = ROW_W'(row);
    in_col = COL_W'(col); in_write = wr; in_tag = TAG_W'(tag);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input int tag, input int b, input string rq);
    exp_t e;
    e.tag = tag; e.bank = b; e.rq = rq;
    exp_q.push_back(e);
  endtask

  task automatic drain();
    int g = 0;
    @(posedge clk); #1 out_ready = 1'b1;
    while (exp_q.size() != 0 && g < 500) begin @(posedge clk); g++; end
    check(exp_q.size() == 0, "R9 pending", exp_q.size(), 0);
    @(posedge clk); #1 out_ready = 1'b0;
    @(negedge clk);
    check(out_valid_o == 1'b0, "R9 idle", int'(out_valid_o), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid_o && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected", int'(out_tag_o), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(int'(out_tag_o) == e.tag, e.rq, int'(out_tag_o), e.tag);
        check(int'(out_bank_o) == e.bank, e.rq, int'(out_bank_o), e.bank);
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid_o == 1'b0, "R1 valid", int'(out_valid_o), 0);
    check(in_ready_o == 1'b1, "R1 ready", int'(in_ready_o), 1);

    // R2 same-row bursts, bank 0
    push(0, 5, 0, 0, 10); push(0, 7, 0, 0, 11);
    push(0, 5, 1, 0, 12); push(0, 7, 1, 0, 13);
    expect_out(10, 0, "R7 R2"); expect_out(12, 0, "R2");
    expect_out(11, 0, "R2");    expect_out(13, 0, "R2");
    drain();

    // R3 read first, R5 write piggyback, bank 1
    push(1, 3, 1, 1, 20); push(1, 3, 2, 0, 21);
    push(1, 9, 0, 0, 22); push(1, 9, 5, 1, 23);
    expect_out(21, 1, "R3"); expect_out(20, 1, "R5");
    expect_out(22, 1, "R3"); expect_out(23, 1, "R5");
    drain();

    // R8 same-address ordering, bank 2
    push(2, 2, 4, 1, 30); push(2, 2, 4, 0, 31); push(2, 2, 6, 0, 32);
    expect_out(32, 2, "R8"); expect_out(30, 2, "R8 R5"); expect_out(31, 2, "R8");
    drain();

    // R4 write threshold, bank 3
    for (int i = 0; i < 6; i++) push(3, 1, i, 1, 50 + i);
    push(3, 1, 9, 0, 56);
    expect_out(50, 3, "R4"); expect_out(56, 3, "R4 R2");
    for (int i = 1; i < 6; i++) expect_out(50 + i, 3, "R5");
    drain();

    // R7 round robin, last served bank 3
    push(0, 1, 0, 0, 60); push(0, 1, 1, 0, 61);
    push(1, 1, 0, 0, 62); push(2, 1, 0, 0, 63);
    expect_out(60, 0, "R7"); expect_out(62, 1, "R7");
    expect_out(63, 2, "R7"); expect_out(61, 0, "R7");
    drain();

    // R6 full bank
    for (int i = 0; i < 8; i++) push(0, 4, i, 0, 40 + i);
    @(posedge clk); #1 in_valid = 1'b0; in_bank = 2'd0;
    @(negedge clk);
    check(in_ready_o == 1'b0, "R6 full", int'(in_ready_o), 0);
    @(posedge clk); #1 in_bank = 2'd1;
    @(negedge clk);
    check(in_ready_o == 1'b1, "R6 other bank", int'(in_ready_o), 1);
    push(0, 4, 30, 0, 99);
    for (int i = 0; i < 8; i++) expect_out(40 + i, 0, "R6");
    drain();

    finish_run();
  end
endmodule